// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual-Cycle Deselect

This block is a behavioural, synthesizable model of a small synchronous burst SRAM. Its words are 36 bits wide, made of four 9-bit bytes, and the array holds 256 words. Each rising clock edge is decoded into one of five cycle kinds: deselect, begin-read, begin-write, continue or suspend. The decode looks at two address strobes, an advance input, three chip enables and the write controls.

Writes can be global or byte-masked and are applied to the internal array. Read data is driven in one of two modes, chosen by a mode input:

- **Flow-through:** data is driven in the cycle that follows the command edge.
- **Pipelined:** data goes through an output register and appears one clock later.

A deselect travels down the same pipeline as a read. The drivers therefore stay on for one full cycle after the deselect edge. They go off only after the second rising edge.

The tri-state data bus is modelled as two signals, a data output and a drive-enable. An asynchronous output enable can force the drivers off at any time. A sleep input blocks all accesses but keeps the array contents.

Top module: `burst_sram`

## Requirements
- R1: When `gw_n` is low at an edge that starts or continues a write access, all four bytes are written from `din`, whatever `bw_n` and `be_n` are.
- R2: When `gw_n` is high and `bw_n` is low, each byte i whose `be_n[i]` is low is written. Byte i occupies `din[9*i+8:9*i]`. When `bw_n` is high, or all `be_n` bits are high, the cycle is a read.
- R3: If `strp_n` and `ce_n` are both low, and the two secondary enables are met, the cycle begins a read at `addr` even when the write controls request a write. If `ce_n` is high, `strp_n` is ignored.
- R4: If `strc_n` is low while `strp_n` does not start a cycle, the cycle begins a burst at `addr` only when all three enables are met (`ce_n` low, `ce2` high, `ce3_n` low). Otherwise it is a deselect. `ce2` and `ce3_n` are ignored on continue and suspend cycles.
- R5: With both strobes inactive in a selected burst:
  - `adv_n` low moves the burst to its next address. Bits [1:0] are the start bits XOR a 2-bit count, so the burst wraps back to the start address on the fifth access.
  - `adv_n` high repeats the current address.
  - Whether the cycle reads or writes follows the write controls.
- R6: `dout_en` is low during every write cycle, even when an earlier read is still pending. A read drives all 36 bits.
- R7: With `flow_n` high (pipeline), read data and `dout_en` appear after the edge that follows the read command edge. With `flow_n` low (flow-through), they appear right after the command edge.
- R8: Outputs are off after reset. After a deselect edge that follows a read, the outputs stay driven for one cycle and turn off after the next rising edge.
- R9: `oe_n` high turns `dout_en` off at once, without waiting for a clock edge. `oe_n` low enables the drivers only in cycles that would otherwise drive read data.
- R10: Read cycles that run with `oe_n` high still advance the burst address.
- R11: While `sleep` is high, no access is performed, the contents of the array are kept, and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | 8 | External word address |
| strp_n | input | 1 | Processor address strobe, active low, always starts a read |
| strc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low; also masks `strp_n` |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte write, active low |
| be_n | input | 4 | Per-byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | Low selects flow-through, high selects pipeline |
| sleep | input | 1 | Standby request, active high |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | High when the data drivers are on |

## Verification
Several functions can collide in one cycle:

- **Pipeline against write:** a pipelined read can still be waiting to be driven when a write command arrives. The bench issues a read immediately followed by a write and checks that `dout_en` stays low over the write cycle. It then reads the written word back.
- **Sleep against a pending read:** sleep can land on the cycle in which pipelined read data would appear. The bench raises `sleep` on that edge and expects the drivers to be off. It then drops `sleep` in the middle of the cycle and expects the same data to reappear, which shows that the read was not lost.
- **Output enable against a burst:** output enable can be high across burst read cycles. The bench confirms that the address still advanced by checking the data at the third burst address once `oe_n` falls.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  parameter int DEPTH  = 256,
  parameter bit LINEAR = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(DEPTH)-1:0]  addr,
  input  logic                      strp_n,
  input  logic                      strc_n,
  input  logic                      adv_n,
  input  logic                      ce_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      gw_n,
  input  logic                      bw_n,
  input  logic [BYTES-1:0]          be_n,
  input  logic                      oe_n,
  input  logic                      flow_n,
  input  logic                      sleep,
  input  logic [BYTES*BYTE_W-1:0]   din,
  output logic [BYTES*BYTE_W-1:0]   dout,
  output logic                      dout_en
);
  localparam int W  = BYTES * BYTE_W;
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {K_DESEL, K_RD, K_WR} kind_t;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] base_q, s1_addr, acc_addr;
  logic [1:0]    cnt_q;
  logic          sel_q, begin_cyc, adv_cyc;
  kind_t         s1_kind, s2_kind, nxt_kind;
  logic [W-1:0]  dq, rd_data;
  logic          drive;

  wire sel_now = !ce_n && ce2 && !ce3_n;
  wire p_start = !strp_n && !ce_n;
  wire wr_req  = !gw_n || (!bw_n && !(&be_n));
  wire [BYTES-1:0] wmask = !gw_n ? {BYTES{1'b1}} : (!bw_n ? ~be_n : {BYTES{1'b0}});

  wire [1:0] lo_cur = LINEAR ? base_q[1:0] + cnt_q : base_q[1:0] ^ cnt_q;
  wire [1:0] lo_nxt = LINEAR ? base_q[1:0] + cnt_q + 2'd1 : base_q[1:0] ^ (cnt_q + 2'd1);
  wire [AW-1:0] cur_addr = {base_q[AW-1:2], lo_cur};
  wire [AW-1:0] nxt_addr = {base_q[AW-1:2], lo_nxt};

  always_comb begin
    begin_cyc = 1'b0;
    adv_cyc   = 1'b0;
    nxt_kind  = K_DESEL;
    acc_addr  = cur_addr;
    if (sleep) begin
      nxt_kind = K_DESEL;
    end else if (p_start) begin
      if (ce2 && !ce3_n) begin
        begin_cyc = 1'b1;
        nxt_kind  = K_RD;
        acc_addr  = addr;
      end
    end else if (!strc_n) begin
      if (sel_now) begin
        begin_cyc = 1'b1;
        nxt_kind  = wr_req ? K_WR : K_RD;
        acc_addr  = addr;
      end
    end else if (sel_q) begin
      adv_cyc  = !adv_n;
      nxt_kind = wr_req ? K_WR : K_RD;
      acc_addr = adv_n ? cur_addr : nxt_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      s1_kind <= K_DESEL;
      s2_kind <= K_DESEL;
      s1_addr <= '0;
      dq      <= '0;
    end else begin
      if (begin_cyc) begin
        base_q <= addr;
        cnt_q  <= 2'd0;
      end else if (adv_cyc) begin
        cnt_q <= cnt_q + 2'd1;
      end
      sel_q   <= (nxt_kind != K_DESEL);
      s1_kind <= nxt_kind;
      s1_addr <= acc_addr;
      s2_kind <= s1_kind;
      dq      <= mem[s1_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && nxt_kind == K_WR)
      for (int i = 0; i < BYTES; i++)
        if (wmask[i]) mem[acc_addr][i*BYTE_W +: BYTE_W] <= din[i*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (flow_n) begin
      drive   = (s2_kind == K_RD);
      rd_data = dq;
    end else begin
      drive   = (s1_kind == K_RD) || (s1_kind == K_DESEL && s2_kind == K_RD);
      rd_data = (s1_kind == K_RD) ? mem[s1_addr] : dq;
    end
  end

  assign dout_en = drive && (s1_kind != K_WR) && !oe_n && !sleep;
  assign dout    = dout_en ? rd_data : '0;

  wire cmd_rd    = (nxt_kind == K_RD);
  wire cmd_wr    = (nxt_kind == K_WR);
  wire cmd_desel = (nxt_kind == K_DESEL);

  assert_wr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !dout_en);

  assert_dcd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_desel ##1 cmd_desel |=> !dout_en);

  assert_dcd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd ##1 cmd_desel |=> (dout_en || oe_n || sleep));

  assert_pstrobe_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strp_n && !ce_n && ce2 && !ce3_n && !sleep) |=> (s1_kind == K_RD));

  assert_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strc_n && !(!strp_n && !ce_n) && !(!ce_n && ce2 && !ce3_n)) |=> (s1_kind == K_DESEL));

  assert_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (s1_kind == K_DESEL));
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr;
  logic strp_n, strc_n, adv_n, ce_n, ce2, ce3_n, gw_n, bw_n, oe_n, flow_n, sleep;
  logic [3:0] be_n;
  logic [W-1:0] din, dout;
  logic dout_en;
  int checks = 0, failures = 0;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strp_n(strp_n), .strc_n(strc_n),
    .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bw_n(bw_n),
    .be_n(be_n), .oe_n(oe_n), .flow_n(flow_n), .sleep(sleep), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  task automatic step;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_off(input string tag);
    chk(dout_en === 1'b0, tag, {35'd0, dout_en}, '0);
  endtask

  task automatic chk_data(input string tag, input logic [W-1:0] exp);
    chk(dout_en === 1'b1, tag, {35'd0, dout_en}, 36'd1);
    chk(dout === exp, tag, dout, exp);
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw, input logic [3:0] ben);
    logic [W-1:0] r = old;
    for (int i = 0; i < 4; i++) if (!ben[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic set_desel;
    strp_n = 1; strc_n = 0; adv_n = 1; ce_n = 1; ce2 = 1; ce3_n = 0;
    gw_n = 1; bw_n = 1; be_n = 4'hF; din = '0; addr = '0;
  endtask

  task automatic desel;
    set_desel(); step();
  endtask

  task automatic begin_c(input logic [7:0] a, input logic g, input logic b, input logic [3:0] be, input logic [W-1:0] d);
    strp_n = 1; strc_n = 0; adv_n = 1; ce_n = 0; ce2 = 1; ce3_n = 0;
    addr = a; gw_n = g; bw_n = b; be_n = be; din = d;
    step();
  endtask

  task automatic cont(input logic adv, input logic g, input logic [W-1:0] d);
    strp_n = 1; strc_n = 1; ce_n = 0; ce2 = 1; ce3_n = 0; adv_n = adv;
    gw_n = g; bw_n = 1; be_n = 4'hF; din = d; addr = 8'hEE;
    step();
  endtask

  task automatic write_full(input logic [7:0] a, input logic [W-1:0] d);
    begin_c(a, 0, 1, 4'hF, d); desel();
  endtask

  task automatic read_pipe(input logic [7:0] a, input logic [W-1:0] exp, input string tag);
    begin_c(a, 1, 1, 4'hF, '0);
    chk_off({tag, " R7 pipeline not yet driven"});
    desel();
    chk_data({tag, " R7 pipeline data"}, exp);
    desel();
    chk_off({tag, " R8 off after second edge"});
  endtask

  localparam logic [W-1:0] DA = 36'h1_2345_6789, DB = 36'hA_BCDE_F012, DC = 36'h5_5AA5_5AA5;
  localparam logic [W-1:0] DD = 36'hF_FFFF_FFFF, DE = 36'h0_DEAD_BEEF, DF = 36'h3_1415_9265;

  logic [W-1:0] m11, bd [6];

  task automatic t_reset;
    chk_off("R8 reset state");
  endtask

  task automatic t_global;
    begin_c(8'd10, 0, 0, 4'b1110, DA); desel();
    read_pipe(8'd10, DA, "R1 global write");
  endtask

  task automatic t_bytes;
    write_full(8'd11, DB);
    begin_c(8'd11, 1, 0, 4'b1010, DC); desel();
    m11 = merge(DB, DC, 4'b1010);
    read_pipe(8'd11, m11, "R2 masked write");
    begin_c(8'd11, 1, 1, 4'b0000, DD);
    desel();
    chk_data("R2 bw high is a read", m11);
    desel();
    begin_c(8'd11, 1, 0, 4'b1111, DD); desel(); desel();
    read_pipe(8'd11, m11, "R2 no byte enabled");
  endtask

  task automatic t_pstrobe;
    strp_n = 0; strc_n = 1; ce_n = 0; ce2 = 1; ce3_n = 0; adv_n = 1;
    gw_n = 0; bw_n = 0; be_n = 4'h0; addr = 8'd11; din = DD;
    step();
    chk_off("R3 strobe read latency");
    desel();
    chk_data("R3 strobe forces read", m11);
    desel();
    strp_n = 0; strc_n = 1; ce_n = 1; ce2 = 1; ce3_n = 0; adv_n = 0;
    gw_n = 0; addr = 8'd11; din = DD;
    step();
    desel();
    chk_off("R3 masked strobe no access");
    read_pipe(8'd11, m11, "R3 masked strobe no write");
  endtask

  task automatic t_secondary;
    write_full(8'd12, DF);
    strp_n = 1; strc_n = 0; ce_n = 0; ce2 = 0; ce3_n = 0; gw_n = 0; addr = 8'd12; din = DE;
    step(); desel();
    strp_n = 1; strc_n = 0; ce_n = 0; ce2 = 1; ce3_n = 1; gw_n = 0; addr = 8'd12; din = DE;
    step(); desel();
    read_pipe(8'd12, DF, "R4 enables not met");
    begin_c(8'd20, 0, 1, 4'hF, DA);
    strp_n = 1; strc_n = 1; ce_n = 1; ce2 = 0; ce3_n = 1; adv_n = 0; gw_n = 0; din = DE;
    step(); desel();
    read_pipe(8'd21, DE, "R4 secondary ignored on continue");
  endtask

  task automatic t_burst;
    for (int i = 0; i < 6; i++) bd[i] = 36'h1_0000_0000 * (i + 1) + 36'h111 * (i + 1);
    begin_c(8'h31, 0, 1, 4'hF, bd[0]);
    cont(0, 0, bd[1]);
    cont(0, 0, bd[2]);
    cont(0, 0, bd[3]);
    cont(0, 0, bd[4]);
    cont(1, 0, bd[5]);
    desel();
    begin_c(8'h30, 1, 1, 4'hF, '0);
    chk_off("R5 burst read latency");
    cont(0, 1, '0);
    chk_data("R5 burst word 0x30", bd[1]);
    cont(0, 1, '0);
    chk_data("R5 burst wrap and suspend 0x31", bd[5]);
    cont(0, 1, '0);
    chk_data("R5 interleaved 0x32", bd[3]);
    desel();
    chk_data("R5 interleaved 0x33", bd[2]);
    desel();
    chk_off("R8 burst end off");
  endtask

  task automatic t_write_off;
    begin_c(8'd10, 1, 1, 4'hF, '0);
    begin_c(8'd13, 0, 1, 4'hF, DE);
    chk_off("R6 write cycle drivers off");
    desel();
    chk_off("R6 after write off");
    desel();
    read_pipe(8'd13, DE, "R6 full word read");
  endtask

  task automatic t_oe;
    begin_c(8'd10, 1, 1, 4'hF, '0);
    desel();
    chk_data("R9 driven before oe", DA);
    oe_n = 1; #1;
    chk_off("R9 oe high async off");
    oe_n = 0; #1;
    chk_data("R9 oe low re-enables", DA);
    desel();
    chk_off("R8 after oe test");
  endtask

  task automatic t_dummy;
    oe_n = 1;
    begin_c(8'h30, 1, 1, 4'hF, '0);
    cont(0, 1, '0);
    chk_off("R10 dummy read not driven");
    oe_n = 0;
    cont(0, 1, '0);
    chk_data("R10 counter advanced in dummy read", bd[5]);
    desel();
    chk_data("R10 third address", bd[3]);
    desel();
  endtask

  task automatic t_sleep;
    sleep = 1;
    begin_c(8'd10, 0, 1, 4'hF, DF);
    chk_off("R11 sleep off");
    sleep = 0;
    desel();
    read_pipe(8'd10, DA, "R11 sleep blocked write");
    begin_c(8'd10, 1, 1, 4'hF, '0);
    sleep = 1;
    desel();
    chk_off("R11 sleep hides pending read");
    sleep = 0; #1;
    chk_data("R11 data kept after sleep", DA);
    desel();
    chk_off("R8 after sleep");
  endtask

  task automatic t_flow;
    flow_n = 0;
    desel();
    begin_c(8'd10, 1, 1, 4'hF, '0);
    chk_data("R7 flow-through same cycle", DA);
    desel();
    chk_data("R8 flow-through deselect hold", DA);
    desel();
    chk_off("R8 flow-through off after second edge");
    flow_n = 1;
  endtask

  initial begin
    set_desel();
    oe_n = 0; flow_n = 1; sleep = 0;
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_global();
    t_bytes();
    t_pstrobe();
    t_secondary();
    t_burst();
    t_write_off();
    t_oe();
    t_dummy();
    t_sleep();
    t_flow();
    summary();
  end
endmodule